// File: doc/BRIEF.md
# Simplex Controller Selection Switch

This block decides which of two actuation commands reaches the plant. One command is produced by a high-performance controller that is not trusted and is read from a shared register. The other comes from a local, trusted safety controller. The block samples its inputs only on a periodic evaluation tick. On that tick it looks at the execution-timing alarm from a side-channel monitor, at the cart position and pendulum angle, and at both candidate commands. It then registers one command onto the actuator output.

In normal operation the untrusted command is forwarded. A timing alarm, or a plant state outside the safety envelope, moves control to the safety controller and raises the alarm output. The envelope is violated when the magnitude of the position or of the angle is strictly above its programmable limit. Once tripped, the switch stays on the safety controller until the trusted reset is applied. Two sticky cause flags record whether the timing path, the physical path, or both caused the trip.

Top module: `simplex_switch`

## Requirements
- R1: While rst_n is low and after its release, act_cmd_o is 0, and safe_mode_o, cause_timing_o and cause_phys_o are 0.
- R2: On a tick with no timing alarm, no envelope violation and safe_mode_o at 0, act_cmd_o takes the value of cmd_untrusted_i at that tick, visible from the next clock cycle.
- R3: In cycles without a tick, act_cmd_o, safe_mode_o and the cause flags keep their values whatever the other inputs do.
- R4: On a tick with timing_alarm_i high, safe_mode_o and cause_timing_o go to 1, and act_cmd_o takes cmd_safe_i from the same tick.
- R5: The position check trips when |pos_i| > pos_lim_i. A magnitude equal to the limit does not trip it, for either sign. A trip sets cause_phys_o and safe_mode_o and selects cmd_safe_i.
- R6: The angle check behaves like R5 with ang_i and ang_lim_i, and negative angles trip through their magnitude.
- R7: Once safe_mode_o is 1 it stays 1 until rst_n is asserted. Every later tick forwards the cmd_safe_i sampled on that tick, even when the inputs are clean.
- R8: The cause flags are sticky and independent. A timing alarm after a physical trip also sets cause_timing_o, and cause_phys_o stays set.
- R9: A sensor value equal to the most negative code has a magnitude one above the largest positive limit, so it trips against that limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Trusted asynchronous active-low reset |
| tick | input | 1 | Evaluation strobe, one cycle wide |
| timing_alarm_i | input | 1 | Timing side-channel violation |
| pos_i | input | SENS_W | Cart position, signed |
| ang_i | input | SENS_W | Pendulum angle, signed |
| pos_lim_i | input | SENS_W | Position magnitude limit, signed |
| ang_lim_i | input | SENS_W | Angle magnitude limit, signed |
| cmd_untrusted_i | input | CMD_W | Command from the shared register |
| cmd_safe_i | input | CMD_W | Command from the safety controller |
| act_cmd_o | output | CMD_W | Registered actuator command |
| safe_mode_o | output | 1 | Alarm: safety controller in charge |
| cause_timing_o | output | 1 | Sticky: timing caused a trip |
| cause_phys_o | output | 1 | Sticky: envelope caused a trip |

## Verification
The assertions assume that tick is a one-cycle strobe and that all inputs are stable around the clock edge. They also assume the limits do not change in the cycle the envelope is evaluated. The stimulus changes inputs only on the falling edge and raises tick for exactly one cycle. It moves the limits only while tick is low. Timing alarms and out-of-range sensor values are also applied between ticks, which shows that only the tick samples them.

// File: rtl/simplex_pkg.sv
package simplex_pkg;
  typedef struct packed {
    logic timing;
    logic phys;
  } trip_cause_t;

  typedef enum logic {
    SRC_COMPLEX = 1'b0,
    SRC_SAFETY  = 1'b1
  } cmd_src_e;
endpackage

// File: rtl/limit_cmp.sv
module limit_cmp #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] val_i,
  input  logic signed [W-1:0] lim_i,
  output logic                exceed_o
);
  localparam int EW = W + 1;

  logic signed [EW-1:0] val_ext;
  logic signed [EW-1:0] lim_ext;
  logic signed [EW-1:0] mag;

  always_comb begin
    val_ext  = {val_i[W-1], val_i};
    lim_ext  = {lim_i[W-1], lim_i};
    mag      = (val_ext < 0) ? -val_ext : val_ext;
    exceed_o = (mag > lim_ext);
  end
endmodule

// File: rtl/envelope_check.sv
module envelope_check #(
  parameter int SENS_W = 16
) (
  input  logic signed [SENS_W-1:0] pos_i,
  input  logic signed [SENS_W-1:0] ang_i,
  input  logic signed [SENS_W-1:0] pos_lim_i,
  input  logic signed [SENS_W-1:0] ang_lim_i,
  output logic                     viol_o
);
  localparam int N_AXIS = 2;

  logic signed [SENS_W-1:0] vals [N_AXIS];
  logic signed [SENS_W-1:0] lims [N_AXIS];
  logic [N_AXIS-1:0]        axis_viol;

  always_comb begin
    vals[0] = pos_i;
    vals[1] = ang_i;
    lims[0] = pos_lim_i;
    lims[1] = ang_lim_i;
  end

  for (genvar g = 0; g < N_AXIS; g++) begin : g_axis
    limit_cmp #(.W(SENS_W)) u_cmp (
      .val_i    (vals[g]),
      .lim_i    (lims[g]),
      .exceed_o (axis_viol[g])
    );
  end

  assign viol_o = |axis_viol;
endmodule

// File: rtl/mode_latch.sv
module mode_latch
  import simplex_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        timing_alarm_i,
  input  logic        phys_viol_i,
  output cmd_src_e    src_next_o,
  output logic        safe_q_o,
  output trip_cause_t cause_q_o
);
  logic        safe_q, safe_d;
  trip_cause_t cause_q, cause_d;

  always_comb begin
    safe_d  = safe_q;
    cause_d = cause_q;
    if (tick) begin
      cause_d.timing = cause_q.timing | timing_alarm_i;
      cause_d.phys   = cause_q.phys   | phys_viol_i;
      safe_d         = safe_q | timing_alarm_i | phys_viol_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      safe_q  <= 1'b0;
      cause_q <= '0;
    end else if (tick) begin
      safe_q  <= safe_d;
      cause_q <= cause_d;
    end
  end

  assign src_next_o = safe_d ? SRC_SAFETY : SRC_COMPLEX;
  assign safe_q_o   = safe_q;
  assign cause_q_o  = cause_q;

  a_r7_latched: assert property (@(posedge clk) disable iff (!rst_n)
    safe_q |=> safe_q);
  a_r8_cause_present: assert property (@(posedge clk) disable iff (!rst_n)
    safe_q |-> (cause_q.timing | cause_q.phys));
  a_r8_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q.timing && cause_q.phys) |=> (cause_q.timing && cause_q.phys));
endmodule

// File: rtl/cmd_select.sv
module cmd_select
  import simplex_pkg::*;
#(
  parameter int CMD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  cmd_src_e         src_i,
  input  logic [CMD_W-1:0] cmd_untrusted_i,
  input  logic [CMD_W-1:0] cmd_safe_i,
  output logic [CMD_W-1:0] act_cmd_o
);
  logic [CMD_W-1:0] act_q, act_d;

  always_comb begin
    act_d = act_q;
    if (tick) act_d = (src_i == SRC_SAFETY) ? cmd_safe_i : cmd_untrusted_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_q <= '0;
    else if (tick) act_q <= act_d;
  end

  assign act_cmd_o = act_q;

  a_r3_hold_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(act_cmd_o));
endmodule

// File: rtl/simplex_switch.sv
module simplex_switch
  import simplex_pkg::*;
#(
  parameter int CMD_W  = 16,
  parameter int SENS_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     timing_alarm_i,
  input  logic signed [SENS_W-1:0] pos_i,
  input  logic signed [SENS_W-1:0] ang_i,
  input  logic signed [SENS_W-1:0] pos_lim_i,
  input  logic signed [SENS_W-1:0] ang_lim_i,
  input  logic [CMD_W-1:0]         cmd_untrusted_i,
  input  logic [CMD_W-1:0]         cmd_safe_i,
  output logic [CMD_W-1:0]         act_cmd_o,
  output logic                     safe_mode_o,
  output logic                     cause_timing_o,
  output logic                     cause_phys_o
);
  logic        phys_viol;
  cmd_src_e    src_next;
  logic        safe_q;
  trip_cause_t cause_q;

  envelope_check #(.SENS_W(SENS_W)) u_env (
    .pos_i     (pos_i),
    .ang_i     (ang_i),
    .pos_lim_i (pos_lim_i),
    .ang_lim_i (ang_lim_i),
    .viol_o    (phys_viol)
  );

  mode_latch u_mode (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick           (tick),
    .timing_alarm_i (timing_alarm_i),
    .phys_viol_i    (phys_viol),
    .src_next_o     (src_next),
    .safe_q_o       (safe_q),
    .cause_q_o      (cause_q)
  );

  cmd_select #(.CMD_W(CMD_W)) u_sel (
    .clk             (clk),
    .rst_n           (rst_n),
    .tick            (tick),
    .src_i           (src_next),
    .cmd_untrusted_i (cmd_untrusted_i),
    .cmd_safe_i      (cmd_safe_i),
    .act_cmd_o       (act_cmd_o)
  );

  assign safe_mode_o    = safe_q;
  assign cause_timing_o = cause_q.timing;
  assign cause_phys_o   = cause_q.phys;

  a_r2_pass_untrusted: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !timing_alarm_i && !phys_viol && !safe_mode_o)
      |=> (act_cmd_o == $past(cmd_untrusted_i)));
  a_r4_timing_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && timing_alarm_i) |=> (safe_mode_o && cause_timing_o));
  a_r5_phys_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && phys_viol) |=> (safe_mode_o && cause_phys_o));
  a_r7_safe_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && safe_mode_o) |=> (act_cmd_o == $past(cmd_safe_i)));
endmodule

// File: tb/tb_simplex_switch.sv
module tb_simplex_switch;
  localparam int  CMD_W   = 16;
  localparam int  SENS_W  = 16;
  localparam time CLK_PER = 10ns;

  logic clk = 1'b0;
  logic rst_n, tick, timing_alarm;
  logic signed [SENS_W-1:0] pos, ang, pos_lim, ang_lim;
  logic [CMD_W-1:0] cmd_u, cmd_s, act;
  logic safe, c_t, c_p;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PER/2) clk = ~clk;

  simplex_switch #(.CMD_W(CMD_W), .SENS_W(SENS_W)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .timing_alarm_i(timing_alarm),
    .pos_i(pos), .ang_i(ang), .pos_lim_i(pos_lim), .ang_lim_i(ang_lim),
    .cmd_untrusted_i(cmd_u), .cmd_safe_i(cmd_s),
    .act_cmd_o(act), .safe_mode_o(safe),
    .cause_timing_o(c_t), .cause_phys_o(c_p)
  );

  task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expected);
    n_chk++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic chk_state(input string req, input logic [CMD_W-1:0] e_act,
                           input logic e_safe, input logic e_t, input logic e_p);
    chk({req, " act"}, 32'(act), 32'(e_act));
    chk({req, " safe"}, 32'(safe), 32'(e_safe));
    chk({req, " cause_t"}, 32'(c_t), 32'(e_t));
    chk({req, " cause_p"}, 32'(c_p), 32'(e_p));
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic clean_inputs();
    timing_alarm = 1'b0; pos = '0; ang = '0;
    pos_lim = 16'sd1000; ang_lim = 16'sd200;
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    clean_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk) rst_n = 1'b0;
    #1 chk_state("R1 during reset", '0, 0, 0, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_state("R1 after release", '0, 0, 0, 0);
  endtask

  task automatic t_pass();
    cmd_u = 16'h1234; cmd_s = 16'h0BAD;
    do_tick();
    chk_state("R2 pass first", 16'h1234, 0, 0, 0);
    cmd_u = 16'hBEEF; pos = 16'sd500; ang = -16'sd100;
    do_tick();
    chk_state("R2 pass second", 16'hBEEF, 0, 0, 0);
  endtask

  task automatic t_hold();
    @(negedge clk);
    cmd_u = 16'h7777; timing_alarm = 1'b1; pos = 16'sd5000;
    repeat (3) @(negedge clk);
    chk_state("R3 ignored off tick", 16'hBEEF, 0, 0, 0);
    timing_alarm = 1'b0; pos = '0;
    @(negedge clk);
    chk_state("R3 still held", 16'hBEEF, 0, 0, 0);
  endtask

  task automatic t_pos_bound();
    cmd_u = 16'h1111; pos = 16'sd1000;
    do_tick();
    chk_state("R5 equal positive limit", 16'h1111, 0, 0, 0);
    cmd_u = 16'h2222; pos = -16'sd1000;
    do_tick();
    chk_state("R5 equal negative limit", 16'h2222, 0, 0, 0);
    cmd_u = 16'h3333; cmd_s = 16'h0BAD; pos = 16'sd1001;
    do_tick();
    chk_state("R5 position trip", 16'h0BAD, 1, 0, 1);
  endtask

  task automatic t_latch();
    pos = '0; cmd_u = 16'h4444; cmd_s = 16'h5AFE;
    do_tick();
    chk_state("R7 latched on clean tick", 16'h5AFE, 1, 0, 1);
    timing_alarm = 1'b1; cmd_s = 16'h6666;
    do_tick();
    timing_alarm = 1'b0;
    chk_state("R8 both causes", 16'h6666, 1, 1, 1);
    repeat (3) do_tick();
    chk_state("R8 causes stay", 16'h6666, 1, 1, 1);
  endtask

  task automatic t_ang();
    do_reset();
    chk_state("R7 cleared by reset", '0, 0, 0, 0);
    cmd_u = 16'hA0A0; cmd_s = 16'hC0C0; ang = -16'sd200;
    do_tick();
    chk_state("R6 equal angle limit", 16'hA0A0, 0, 0, 0);
    ang = -16'sd201;
    do_tick();
    chk_state("R6 negative angle trip", 16'hC0C0, 1, 0, 1);
  endtask

  task automatic t_timing();
    do_reset();
    cmd_u = 16'h0101; cmd_s = 16'h0202; timing_alarm = 1'b1;
    do_tick();
    timing_alarm = 1'b0;
    chk_state("R4 timing trip", 16'h0202, 1, 1, 0);
  endtask

  task automatic t_extreme();
    do_reset();
    ang_lim = 16'sh7FFF; pos_lim = 16'sh7FFF;
    cmd_u = 16'h0E0E; cmd_s = 16'h0F0F; ang = 16'sh7FFF;
    do_tick();
    chk_state("R9 max positive no trip", 16'h0E0E, 0, 0, 0);
    ang = 16'sh8000;
    do_tick();
    chk_state("R9 most negative trips", 16'h0F0F, 1, 0, 1);
  endtask

  initial begin
    rst_n = 1'b1; tick = 1'b0; cmd_u = '0; cmd_s = '0;
    clean_inputs();
    t_reset();
    t_pass();
    t_hold();
    t_pos_bound();
    t_latch();
    t_ang();
    t_timing();
    t_extreme();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule